// File: doc/BRIEF.md
# Clock-Generator Configuration Slave (SMBus block mode)

This block is a two-wire serial slave that lets a host read and change the
nine 8-bit configuration registers of a multi-output clock generator. SCL and
SDA arrive as raw pad levels and are resampled on a fast system clock. The
block pulls SDA low only through an active-high drive-enable, and it presents
the register contents as parallel control buses: output enables, spread
selects, slew selects, frequency selects and output amplitude.

A transfer first sends the 7-bit slave address 0x69, so the write address byte
is 0xD2 and the read address byte is 0xD3. The next byte is a command holding
the starting index. If bit 7 of the command is 0, block mode applies. A block
write then carries a byte count and that many data bytes. A block read (a
repeated start followed by 0xD3) returns a count byte first and then the data.
If bit 7 is 1, byte mode applies and the data bytes follow the index directly,
with no count in either direction. After every data byte the index moves on by
one.

The count returned on block reads is not supplied by the host. It comes from a
writable register. Some register bits are loaded from strap pins once, just
after reset.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only address bytes 0xD2 (write) and 0xD3 (read). Any other address byte gets no acknowledge, and the slave stays off SDA until the next start.
- R2: In a block write (command bit 7 = 0, then a count X), each of the X data bytes is acknowledged and stored at the current index, starting at N (command bits 6:0). The index then advances by one.
- R3: In a block write, a data byte after the X counted bytes is not acknowledged and is not stored.
- R4: A block read returns register 8 first and then the registers from index N upward, one per byte. This continues for as long as the host acknowledges.
- R5: In byte mode (command bit 7 = 1), no count is sent or returned. Writes and reads begin at index N and advance by one per byte.
- R6: Register 8 resets to 0x05, and writing it changes the count byte that the next block read returns.
- R7: Register 7 reads 0x11 and ignores writes. Register 5 reads 0x00 and ignores writes. Indices above 8 read 0x00, and writes to them have no effect.
- R8: Register 6 bits 5:4 are read-only. They hold {strap_ddr, strap_pcie} as latched after reset, and all other register 6 bits are writable. Register 4 bits 3:2 reset to strap_fs and are writable.
- R9: Reset values are register 0 = 0x07, registers 1 and 2 = 0xFF, register 3 = 0x00, register 4 = {4'b0000, strap_fs, 2'b00} and register 6 = {2'b00, strap_ddr, strap_pcie, 4'b0101}.
- R10: A start or stop condition in the middle of a byte abandons that byte without storing it. A start always begins a fresh address byte, and a stop returns the slave to idle.
- R11: The slave only ever pulls SDA low, and it turns its drive on only while SCL is low.
- R12: The output fields map to register bits as follows: spread_core = reg0[7:5], spread_pcie = reg0[4:3], aux_en = reg0[2:0], en_grp_a = reg1, en_grp_b = reg2, slew_grp = reg3, ddr_slew = reg4[7:6], sys_fsel = reg4[3:2], usb_fsel = reg4[1:0] and pcie_amp = reg6[7:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pad level |
| sda_i | input | 1 | Serial data pad level |
| sda_oe | output | 1 | When 1, pull SDA low |
| strap_fs | input | 2 | Core-frequency strap pins, latched after reset |
| strap_ddr | input | 1 | Memory-frequency strap pin, latched after reset |
| strap_pcie | input | 1 | Serial-link-frequency strap pin, latched after reset |
| spread_core | output | 3 | Core/memory spread select |
| spread_pcie | output | 2 | Serial-link spread select |
| aux_en | output | 3 | Enables for three reference outputs |
| en_grp_a | output | 8 | Output-enable group A |
| en_grp_b | output | 8 | Output-enable group B |
| slew_grp | output | 8 | Slew selects for four outputs |
| ddr_slew | output | 2 | Memory clock slew select |
| sys_fsel | output | 2 | Core clock frequency select |
| usb_fsel | output | 2 | Two low-speed clock frequency selects |
| pcie_amp | output | 2 | Differential output amplitude select |

## Verification
A block-write data byte advances the index and uses up the last unit of the
count on the same SCL rising edge. Whether the next byte is acknowledged
therefore depends on both updates landing in the same cycle. The bench writes
exactly the counted bytes plus one more, then reads the neighbouring registers
back in byte mode. It expects the extra byte to be refused and no register
beyond the counted range to change. A start that arrives while a data byte is
half shifted in is also provoked, and the register that byte would have
reached must read back unchanged.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

  localparam int unsigned IDX_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK_WAIT, S_ACK, S_TX, S_TX_ACK
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_CNT, PH_DATA
  } phase_t;

  // writable bits of each index; zero means fully read-only
  function automatic logic [7:0] reg_wmask(input logic [IDX_W-1:0] idx);
    case (idx)
      8'd5, 8'd7: return 8'h00;
      8'd6:       return 8'hCF;
      8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd8: return 8'hFF;
      default:    return 8'h00;
    endcase
  endfunction

  // value each index holds while reset is asserted
  function automatic logic [7:0] reg_reset(input logic [IDX_W-1:0] idx);
    case (idx)
      8'd0:       return 8'h07;
      8'd1, 8'd2: return 8'hFF;
      8'd6:       return 8'h05;
      8'd7:       return 8'h11;
      8'd8:       return 8'h05;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] merge_write(input logic [7:0] cur,
                                             input logic [7:0] wdat,
                                             input logic [7:0] wmask);
    return (cur & ~wmask) | (wdat & wmask);
  endfunction

  function automatic logic [7:0] tx_pick(input logic count_first,
                                         input logic [7:0] cnt,
                                         input logic [7:0] dat);
    return count_first ? cnt : dat;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  // one extra stage beyond the synchronizer holds the previous level
  logic [STAGES:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];
  assign scl_q = scl_pipe[STAGES];
  assign sda_q = sda_pipe[STAGES];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smbcfg_pkg::*;
#(
  parameter int unsigned NREG      = 9,
  parameter int unsigned CNT_IDX   = 8,
  parameter int unsigned FSEL_IDX  = 4,
  parameter int unsigned STRAP_IDX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_load,
  input  logic [1:0]        strap_fs,
  input  logic              strap_ddr,
  input  logic              strap_pcie,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  output logic [7:0]        cnt_val,
  output logic [NREG*8-1:0] reg_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] WM = reg_wmask(IDX_W'(g));
    localparam logic [7:0] RV = reg_reset(IDX_W'(g));
    logic [7:0] q, nxt;

    always_comb begin
      nxt = q;
      if (wr_en && (wr_idx == IDX_W'(g))) nxt = merge_write(q, wr_data, WM);
      if (strap_load) begin
        if (g == FSEL_IDX)  nxt[3:2] = strap_fs;
        if (g == STRAP_IDX) nxt[5:4] = {strap_ddr, strap_pcie};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RV;
      else        q <= nxt;
    end

    assign reg_flat[g*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = reg_flat[i*8 +: 8];
    end
  end

  assign cnt_val = reg_flat[CNT_IDX*8 +: 8];
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smbcfg_pkg::*;
#(
  parameter logic [6:0] SADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       cnt_val,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic             in_addr
);
  bus_state_t       st;
  phase_t           ph;
  logic [6:0]       sh;
  logic [3:0]       bits;
  logic [IDX_W-1:0] idx;
  logic [7:0]       wleft;
  logic             blk, rd, do_ack, first_tx, host_ack;

  logic [7:0] rx_byte, tx_byte;
  logic       last_bit, data_ok, byte_done;

  assign rx_byte   = {sh, sda_s};
  assign last_bit  = (bits == 4'd7);
  assign data_ok   = !blk || (wleft != 8'd0);
  assign byte_done = (st == S_RX) && scl_rise && last_bit;
  assign tx_byte   = tx_pick(first_tx, cnt_val, rd_data);

  assign wr_en   = byte_done && (ph == PH_DATA) && data_ok;
  assign wr_idx  = idx;
  assign wr_data = rx_byte;
  assign rd_idx  = idx;
  assign busy    = (st != S_IDLE);
  assign in_addr = (st == S_RX) && (ph == PH_ADDR) && (bits == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= PH_ADDR;
      sh       <= '0;
      bits     <= '0;
      idx      <= '0;
      wleft    <= '0;
      blk      <= 1'b1;
      rd       <= 1'b0;
      do_ack   <= 1'b0;
      first_tx <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_evt) begin
      st     <= S_RX;
      ph     <= PH_ADDR;
      bits   <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st     <= S_IDLE;
      ph     <= PH_ADDR;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: if (scl_rise) begin
          sh   <= rx_byte[6:0];
          bits <= bits + 4'd1;
          if (last_bit) begin
            bits   <= '0;
            st     <= S_ACK_WAIT;
            do_ack <= 1'b1;
            case (ph)
              PH_ADDR: begin
                if (rx_byte[7:1] == SADDR) begin
                  rd       <= rx_byte[0];
                  first_tx <= blk;
                  ph       <= rx_byte[0] ? PH_ADDR : PH_CMD;
                end else begin
                  st <= S_IDLE;
                end
              end
              PH_CMD: begin
                idx <= {1'b0, rx_byte[6:0]};
                blk <= ~rx_byte[7];
                ph  <= rx_byte[7] ? PH_DATA : PH_CNT;
              end
              PH_CNT: begin
                wleft <= rx_byte;
                ph    <= PH_DATA;
              end
              PH_DATA: begin
                if (data_ok) begin
                  idx <= idx + 1'b1;
                  if (blk) wleft <= wleft - 8'd1;
                end else begin
                  do_ack <= 1'b0;
                end
              end
              default: ;
            endcase
          end
        end
        S_ACK_WAIT: if (scl_fall) begin
          sda_oe <= do_ack;
          st     <= S_ACK;
        end
        S_ACK: if (scl_fall) begin
          if (rd) begin
            sh       <= tx_byte[6:0];
            sda_oe   <= ~tx_byte[7];
            bits     <= '0;
            st       <= S_TX;
            first_tx <= 1'b0;
            if (!first_tx) idx <= idx + 1'b1;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_RX;
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bits <= bits + 4'd1;
          end else if (scl_fall) begin
            if (bits == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_TX_ACK;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[5:0], 1'b0};
            end
          end
        end
        S_TX_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              sh       <= tx_byte[6:0];
              sda_oe   <= ~tx_byte[7];
              bits     <= '0;
              st       <= S_TX;
              first_tx <= 1'b0;
              if (!first_tx) idx <= idx + 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
  import smbcfg_pkg::*;
#(
  parameter int unsigned NREG        = 9,
  parameter int unsigned CNT_IDX     = 8,
  parameter logic [6:0]  SADDR       = 7'h69,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_fs,
  input  logic       strap_ddr,
  input  logic       strap_pcie,
  output logic [2:0] spread_core,
  output logic [1:0] spread_pcie,
  output logic [2:0] aux_en,
  output logic [7:0] en_grp_a,
  output logic [7:0] en_grp_b,
  output logic [7:0] slew_grp,
  output logic [1:0] ddr_slew,
  output logic [1:0] sys_fsel,
  output logic [1:0] usb_fsel,
  output logic [1:0] pcie_amp
);
  localparam int unsigned FSEL_IDX  = 4;
  localparam int unsigned STRAP_IDX = 6;
  localparam int unsigned B0 = 0;
  localparam int unsigned B1 = 8;
  localparam int unsigned B2 = 16;
  localparam int unsigned B3 = 24;
  localparam int unsigned B4 = FSEL_IDX * 8;
  localparam int unsigned B5 = 40;
  localparam int unsigned B6 = STRAP_IDX * 8;
  localparam int unsigned B7 = 56;
  localparam int unsigned B8 = CNT_IDX * 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en, busy, in_addr, strap_done, strap_load;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data, cnt_val;
  logic [NREG*8-1:0] reg_flat;
  logic unused_cfg_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strap_done <= 1'b0;
    else        strap_done <= 1'b1;
  end
  assign strap_load = ~strap_done;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_proto_fsm #(.SADDR(SADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .cnt_val(cnt_val), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .busy(busy),
    .in_addr(in_addr)
  );

  smb_cfg_regs #(
    .NREG(NREG), .CNT_IDX(CNT_IDX), .FSEL_IDX(FSEL_IDX), .STRAP_IDX(STRAP_IDX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .strap_load(strap_load), .strap_fs(strap_fs),
    .strap_ddr(strap_ddr), .strap_pcie(strap_pcie), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .cnt_val(cnt_val), .reg_flat(reg_flat)
  );

  assign spread_core = reg_flat[B0+7 -: 3];
  assign spread_pcie = reg_flat[B0+4 -: 2];
  assign aux_en      = reg_flat[B0+2 -: 3];
  assign en_grp_a    = reg_flat[B1 +: 8];
  assign en_grp_b    = reg_flat[B2 +: 8];
  assign slew_grp    = reg_flat[B3 +: 8];
  assign ddr_slew    = reg_flat[B4+7 -: 2];
  assign sys_fsel    = reg_flat[B4+3 -: 2];
  assign usb_fsel    = reg_flat[B4+1 -: 2];
  assign pcie_amp    = reg_flat[B6+7 -: 2];

  assign unused_cfg_bits = ^{reg_flat[B4+5 -: 2], reg_flat[B5 +: 8],
                             reg_flat[B6+5 -: 6], reg_flat[B7 +: 8],
                             reg_flat[B8 +: 8], busy, in_addr, scl_s};
endmodule

// File: rtl/cfg_smbus_chk.sv
module cfg_smbus_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       busy,
  input logic       in_addr,
  input logic       strap_done,
  input logic [1:0] strap_bits,
  input logic [7:0] id_byte,
  input logic [7:0] rsv_byte
);
  // R11: the drive-enable only switches on while the resampled SCL is low
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R10: a start always leads to a fresh address byte
  a_r10_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> in_addr);

  // R10: a stop returns the protocol engine to idle
  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy);

  // R8: latched strap bits of register 6 never move after the capture cycle
  a_r8_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(strap_bits));

  // R7: identity register holds its value
  a_r7_id_held: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(id_byte));

  // R7: reserved register holds its value
  a_r7_rsv_held: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rsv_byte));
endmodule

bind cfg_smbus_slave cfg_smbus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .busy(busy), .in_addr(in_addr),
  .strap_done(strap_done), .strap_bits(reg_flat[53:52]),
  .id_byte(reg_flat[63:56]), .rsv_byte(reg_flat[47:40])
);

// File: tb/sim_cfg_smbus_slave.sv
module sim_cfg_smbus_slave;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [1:0] strap_fs = 2'b10;
  logic strap_ddr = 1'b1;
  logic strap_pcie = 1'b0;
  logic [2:0] spread_core, aux_en;
  logic [1:0] spread_pcie, ddr_slew, sys_fsel, usb_fsel, pcie_amp;
  logic [7:0] en_grp_a, en_grp_b, slew_grp;

  int checks = 0;
  int failures = 0;
  int drive_viol = 0;
  logic oe_prev = 1'b0;

  logic [7:0] model [0:8];
  logic [7:0] buf_w [0:15];
  logic [7:0] buf_r [0:15];
  logic       ack_r [0:15];
  logic       ack_tmp;

  always #4 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  cfg_smbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_fs(strap_fs), .strap_ddr(strap_ddr), .strap_pcie(strap_pcie),
    .spread_core(spread_core), .spread_pcie(spread_pcie), .aux_en(aux_en),
    .en_grp_a(en_grp_a), .en_grp_b(en_grp_b), .slew_grp(slew_grp),
    .ddr_slew(ddr_slew), .sys_fsel(sys_fsel), .usb_fsel(usb_fsel),
    .pcie_amp(pcie_amp)
  );

  // R11 monitor: the slave must not begin pulling SDA while the host holds SCL high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_h) drive_viol = drive_viol + 1;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] bmask(input int i);
    if (i == 5 || i == 7 || i > 8) return 8'h00;
    if (i == 6) return 8'hCF;
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_h = b; tick(Q);
    scl_h = 1'b1; tick(2*Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~give_ack);
  endtask

  task automatic xfer_write(input logic [7:0] cmd, input logic blk,
                            input logic [7:0] cnt, input int n);
    bus_start();
    send_byte(8'hD2, ack_tmp);
    send_byte(cmd, ack_tmp);
    if (blk) send_byte(cnt, ack_tmp);
    for (int i = 0; i < n; i++) send_byte(buf_w[i], ack_r[i]);
    bus_stop();
  endtask

  task automatic xfer_read(input logic [7:0] cmd, input int n);
    bus_start();
    send_byte(8'hD2, ack_tmp);
    send_byte(cmd, ack_tmp);
    bus_start();
    send_byte(8'hD3, ack_tmp);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, buf_r[i]);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model[0] = 8'h07; model[1] = 8'hFF; model[2] = 8'hFF; model[3] = 8'h00;
    model[4] = {4'b0000, strap_fs, 2'b00}; model[5] = 8'h00;
    model[6] = {2'b00, strap_ddr, strap_pcie, 4'b0101};
    model[7] = 8'h11; model[8] = 8'h05;

    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R9 / R12: reset values seen at the output buses
    chk("R9 R12 spread_core", {5'd0, spread_core}, {5'd0, model[0][7:5]});
    chk("R9 R12 aux_en", {5'd0, aux_en}, {5'd0, model[0][2:0]});
    chk("R9 en_grp_a", en_grp_a, 8'hFF);
    chk("R9 en_grp_b", en_grp_b, 8'hFF);
    chk("R9 slew_grp", slew_grp, 8'h00);
    chk("R8 sys_fsel strap", {6'd0, sys_fsel}, {6'd0, strap_fs});
    chk("R9 pcie_amp", {6'd0, pcie_amp}, 8'h00);

    // R4 R6 R9: block read from index 0 returns the count 0x05 and then five registers
    xfer_read(8'h00, 6);
    chk("R6 reset count", buf_r[0], 8'h05);
    for (int i = 0; i < 5; i++) chk("R4 R9 block read data", buf_r[i+1], model[i]);

    // R7 R8: read-only and undefined indices in byte mode
    xfer_read(8'h85, 1); chk("R7 reserved reads 0", buf_r[0], 8'h00);
    xfer_read(8'h86, 1); chk("R8 reg6 reset", buf_r[0], model[6]);
    xfer_read(8'h87, 1); chk("R7 id", buf_r[0], 8'h11);
    xfer_read(8'h8C, 1); chk("R7 undefined index", buf_r[0], 8'h00);

    // R1: foreign address is not acknowledged
    bus_start();
    send_byte(8'hA0, ack_tmp);
    bus_stop();
    chk("R1 foreign address nack", {7'd0, ack_tmp}, 8'h00);
    bus_start();
    send_byte(8'hD2, ack_tmp);
    bus_stop();
    chk("R1 own address ack", {7'd0, ack_tmp}, 8'h01);

    // R5 R7 R8: byte-mode write then read-back sweep over every index and two beyond
    for (int idx = 0; idx < 11; idx++) begin
      logic [7:0] v;
      logic [7:0] e;
      v = 8'((idx * 37 + 8'h5A) & 8'hFF);
      buf_w[0] = v;
      xfer_write(8'h80 | 8'(idx), 1'b0, 8'h00, 1);
      chk("R5 byte write ack", {7'd0, ack_r[0]}, 8'h01);
      if (idx < 9) model[idx] = (model[idx] & ~bmask(idx)) | (v & bmask(idx));
      xfer_read(8'h80 | 8'(idx), 1);
      e = (idx < 9) ? model[idx] : 8'h00;
      chk("R5 R7 R8 sweep readback", buf_r[0], e);
    end

    // R12: output buses follow the register bits
    chk("R12 spread_core", {5'd0, spread_core}, {5'd0, model[0][7:5]});
    chk("R12 spread_pcie", {6'd0, spread_pcie}, {6'd0, model[0][4:3]});
    chk("R12 aux_en", {5'd0, aux_en}, {5'd0, model[0][2:0]});
    chk("R12 en_grp_a", en_grp_a, model[1]);
    chk("R12 en_grp_b", en_grp_b, model[2]);
    chk("R12 slew_grp", slew_grp, model[3]);
    chk("R12 ddr_slew", {6'd0, ddr_slew}, {6'd0, model[4][7:6]});
    chk("R12 sys_fsel", {6'd0, sys_fsel}, {6'd0, model[4][3:2]});
    chk("R12 usb_fsel", {6'd0, usb_fsel}, {6'd0, model[4][1:0]});
    chk("R12 pcie_amp", {6'd0, pcie_amp}, {6'd0, model[6][7:6]});

    // R2 R3: block write of count 2 carrying three bytes
    buf_w[0] = 8'hAA; buf_w[1] = 8'h55; buf_w[2] = 8'hC3;
    xfer_write(8'h01, 1'b1, 8'd2, 3);
    chk("R2 first data ack", {7'd0, ack_r[0]}, 8'h01);
    chk("R2 second data ack", {7'd0, ack_r[1]}, 8'h01);
    chk("R3 extra byte nack", {7'd0, ack_r[2]}, 8'h00);
    model[1] = 8'hAA; model[2] = 8'h55;
    xfer_read(8'h81, 3);
    chk("R2 reg1", buf_r[0], model[1]);
    chk("R2 reg2", buf_r[1], model[2]);
    chk("R3 reg3 untouched", buf_r[2], model[3]);

    // R6 R4: shrink the count, then block read from index 0
    buf_w[0] = 8'h03;
    xfer_write(8'h88, 1'b0, 8'h00, 1);
    model[8] = 8'h03;
    xfer_read(8'h00, 4);
    chk("R6 written count", buf_r[0], 8'h03);
    for (int i = 0; i < 3; i++) chk("R4 data after count", buf_r[i+1], model[i]);

    // R10: start in the middle of a data byte
    bus_start();
    send_byte(8'hD2, ack_tmp);
    send_byte(8'h81, ack_tmp);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b0);
    bus_start();
    bus_stop();
    // R10: stop in the middle of a data byte
    bus_start();
    send_byte(8'hD2, ack_tmp);
    send_byte(8'h82, ack_tmp);
    bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
    bus_stop();
    xfer_read(8'h81, 2);
    chk("R10 reg1 after start abort", buf_r[0], model[1]);
    chk("R10 reg2 after stop abort", buf_r[1], model[2]);

    chk("R11 drive only while SCL low", 8'(drive_viol), 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule